// File: doc/BRIEF.md
# Qualified double-rate capture gate

This block sits between a double-data-rate capture bus and an acquisition store. It runs on a single fast clock at twice the bus clock rate, so each fast cycle carries one transfer on `din`. The level of the bus clock comes in with each transfer on `bus_lvl`. A configuration pin, `open_fall`, chooses which edge of the bus clock starts a cycle. When `open_fall` is 0, a rising edge starts the cycle, so a transfer seen with `bus_lvl` high is the opening one. When `open_fall` is 1, a falling edge starts the cycle, so a transfer seen with `bus_lvl` low is the opening one. An opening transfer followed directly by a closing transfer forms one pair, and the pair is held for one bus cycle.

A separate qualifier pin, `qual_in`, is not itself a data channel. The block looks at it only on the next opening transfer. At that point it decides the fate of the held pair: the pair is either sent out as one word of twice the bus width or dropped. The upstream logic delays the qualifier by one bus cycle, so the qualifier seen at an opening transfer governs the pair completed just before it. Capture runs only while `cap_en` is high.

The output is a plain valid strobe with no ready input. A capture bus cannot be stalled, so the store must take every word in the cycle it is offered. Back-pressure is not supported.

Top module: `qdg_top`

## Requirements
- R1: A pair is formed only from an opening transfer that is directly followed, in the next fast cycle, by a closing transfer. In the emitted word, the opening transfer occupies bits DW-1:0 and the closing transfer occupies bits 2*DW-1:DW.
- R2: When `open_fall`=0, a transfer with `bus_lvl`=1 is an opening transfer. When `open_fall`=1, a transfer with `bus_lvl`=0 is an opening transfer. Any other transfer is a closing candidate.
- R3: Suppose an opening transfer arrives while a pair is held, with `qual_in`=1 and `cap_en`=1. Then `out_valid` is 1 in the following fast cycle, and `out_data` holds that pair.
- R4: If `qual_in`=0 at an opening transfer, the held pair is not emitted.
- R5: `qual_in` is looked at only on opening transfers. `out_valid` is never 1 in the cycle after a closing or unpaired transfer.
- R6: If `cap_en`=0 at an opening transfer, `out_valid` stays 0 whatever `qual_in` is.
- R7: A synchronous reset clears `out_valid` and `out_data` to 0 and drops any held pair. After reset, no word is emitted before an opening transfer, a closing transfer and a further opening transfer have arrived.
- R8: A closing candidate that does not directly follow an opening transfer is ignored. A second opening transfer in a row replaces the first half.
- R9: Every opening transfer uses up the held pair, whether or not the pair is emitted. A dropped pair is never emitted later.
- R10: While `out_valid` is 0, `out_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the bus clock rate |
| rst | input | 1 | Synchronous reset, active high |
| cap_en | input | 1 | Capture enable |
| qual_in | input | 1 | Delayed cycle qualifier |
| bus_lvl | input | 1 | Bus clock level for this transfer |
| open_fall | input | 1 | 1: a falling edge opens a cycle |
| din | input | DW | Transfer data |
| out_valid | output | 1 | One-cycle strobe for a qualified pair |
| out_data | output | 2*DW | Qualified pair, opening half in the low bits |

## Verification
At every opening transfer, two things happen in the same fast cycle. The pair held from the previous bus cycle is judged and either emitted or dropped, and the new opening half is latched into the same register file. The bench provokes this collision constantly: back-to-back cycles run with random data, random qualifier and random enable. It also switches polarity and inserts unpaired transfers, so a judgement can fall on a cycle that has just re-framed. After each cycle, a bench reference model predicts whether a word is due and which data it carries. That prediction is compared with both outputs, and the check fails if the emitted word carries the new opening half instead of the old pair.

// File: rtl/qdg_pkg.sv
package qdg_pkg;
  typedef enum logic [1:0] {
    XK_ORPHAN = 2'd0,
    XK_OPEN   = 2'd1,
    XK_CLOSE  = 2'd2
  } xfer_kind_e;
endpackage

// File: rtl/qdg_phase.sv
module qdg_phase
  import qdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_lvl,
  input  logic       open_fall,
  output xfer_kind_e kind
);
  logic is_open;
  logic prev_open_q;

  // Opening level is high for rising-edge framing, low for falling-edge framing.
  assign is_open = (bus_lvl != open_fall);

  always_ff @(posedge clk) begin
    if (rst) prev_open_q <= 1'b0;
    else     prev_open_q <= is_open;
  end

  always_comb begin
    if (is_open)          kind = XK_OPEN;
    else if (prev_open_q) kind = XK_CLOSE;
    else                  kind = XK_ORPHAN;
  end
endmodule

// File: rtl/qdg_pair.sv
module qdg_pair
  import qdg_pkg::*;
#(
  parameter int DW = 16,
  localparam int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  xfer_kind_e    kind,
  input  logic [DW-1:0] din,
  output logic [PW-1:0] held,
  output logic          held_ok
);
  logic [DW-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '0;
      held    <= '0;
      held_ok <= 1'b0;
    end else begin
      unique case (kind)
        XK_OPEN: begin
          lo_q    <= din;
          held_ok <= 1'b0;
        end
        XK_CLOSE: begin
          held    <= {din, lo_q};
          held_ok <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/qdg_gate.sv
module qdg_gate
  import qdg_pkg::*;
#(
  parameter int DW = 16,
  localparam int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  xfer_kind_e    kind,
  input  logic          cap_en,
  input  logic          qual_in,
  input  logic [PW-1:0] held,
  input  logic          held_ok,
  output logic          out_valid,
  output logic [PW-1:0] out_data
);
  logic fire;

  assign fire = (kind == XK_OPEN) && cap_en && qual_in && held_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fire;
      if (fire) out_data <= held;
    end
  end
endmodule

// File: rtl/qdg_top.sv
module qdg_top
  import qdg_pkg::*;
#(
  parameter int DW = 16,
  localparam int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic          qual_in,
  input  logic          bus_lvl,
  input  logic          open_fall,
  input  logic [DW-1:0] din,
  output logic          out_valid,
  output logic [PW-1:0] out_data
);
  xfer_kind_e    kind;
  logic [PW-1:0] held;
  logic          held_ok;

  qdg_phase u_phase (
    .clk(clk), .rst(rst), .bus_lvl(bus_lvl), .open_fall(open_fall), .kind(kind)
  );

  qdg_pair #(.DW(DW)) u_pair (
    .clk(clk), .rst(rst), .kind(kind), .din(din), .held(held), .held_ok(held_ok)
  );

  qdg_gate #(.DW(DW)) u_gate (
    .clk(clk), .rst(rst), .kind(kind), .cap_en(cap_en), .qual_in(qual_in),
    .held(held), .held_ok(held_ok), .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/qdg_checker.sv
module qdg_checker #(
  parameter int DW = 16,
  localparam int PW = 2 * DW
) (
  input logic          clk,
  input logic          rst,
  input logic          cap_en,
  input logic          qual_in,
  input logic          bus_lvl,
  input logic          open_fall,
  input logic          out_valid,
  input logic [PW-1:0] out_data
);
  logic opening;
  assign opening = (bus_lvl != open_fall);

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  assert_enable_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (opening && !cap_en) |=> !out_valid);

  assert_qual_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (opening && !qual_in) |=> !out_valid);

  assert_open_only_R5: assert property (@(posedge clk) disable iff (rst)
    !opening |=> !out_valid);

  assert_fire_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> ($past(qual_in) && $past(cap_en)));

  assert_data_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(out_data));
endmodule

bind qdg_top qdg_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cap_en(cap_en), .qual_in(qual_in), .bus_lvl(bus_lvl),
  .open_fall(open_fall), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_qdg_top.sv
`timescale 1ns/1ps
module sim_qdg_top;
  localparam int DW = 16;
  localparam int PW = 2 * DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cap_en = 1'b0, qual_in = 1'b0, bus_lvl = 1'b0, open_fall = 1'b0;
  logic [DW-1:0] din = '0;
  logic          out_valid;
  logic [PW-1:0] out_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // model state
  logic [DW-1:0] m_lo;
  logic [PW-1:0] m_held, e_data;
  logic          m_ok, m_last, e_valid;

  always #2.5 clk = ~clk;

  qdg_top #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .cap_en(cap_en), .qual_in(qual_in), .bus_lvl(bus_lvl),
    .open_fall(open_fall), .din(din), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic string tag_for(logic lvl, logic fl, logic q, logic e, logic ok);
    if (lvl == fl) return "R5";
    if (!e)        return "R6";
    if (!q)        return "R4";
    if (!ok)       return "R8";
    return "R3";
  endfunction

  task automatic model(logic r, logic lvl, logic fl, logic q, logic e, logic [DW-1:0] d);
    logic op;
    op = (lvl != fl);
    if (r) begin
      m_lo = '0; m_held = '0; m_ok = 1'b0; m_last = 1'b0; e_valid = 1'b0; e_data = '0;
    end else begin
      if (op) begin
        e_valid = e && q && m_ok;
        if (e_valid) e_data = m_held;
        m_ok = 1'b0;
        m_lo = d;
      end else begin
        e_valid = 1'b0;
        if (m_last) begin
          m_held = {d, m_lo};
          m_ok = 1'b1;
        end
      end
      m_last = op;
    end
  endtask

  task automatic check(string tag);
    total++;
    if (out_valid !== e_valid || out_data !== e_data) begin
      bad++;
      $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
               tag, out_valid, out_data, e_valid, e_data);
    end
  endtask

  task automatic step(logic lvl, logic q, logic e, logic [DW-1:0] d, string tag);
    string t;
    t = (tag == "") ? tag_for(lvl, open_fall, q, e, m_ok) : tag;
    bus_lvl = lvl; qual_in = q; cap_en = e; din = d;
    @(posedge clk);
    model(rst, lvl, open_fall, q, e, d);
    @(negedge clk);
    check(t);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    repeat (3) @(negedge clk);
    check("R7");
    rst = 1'b0;
    // R7: first word only after open, close, open
    step(1'b1, 1'b1, 1'b1, 16'h1111, "R7");
    step(1'b0, 1'b1, 1'b1, 16'h2222, "R7");
    // R1, R3: pair emitted with opening half low
    step(1'b1, 1'b1, 1'b1, 16'h3333, "R1");
    if (out_data !== 32'h2222_1111) begin
      bad++; $display("FAIL R1: data=%h expected=%h", out_data, 32'h2222_1111);
    end
    total++;
    // R9: dropped pair not emitted later
    step(1'b0, 1'b1, 1'b1, 16'h4444, "R9");
    step(1'b1, 1'b0, 1'b1, 16'h5555, "R9");
    step(1'b0, 1'b1, 1'b1, 16'h6666, "R9");
    step(1'b0, 1'b1, 1'b1, 16'h7777, "R8");
    step(1'b1, 1'b1, 1'b1, 16'h8888, "R9");
    step(1'b0, 1'b1, 1'b1, 16'h9999, "R10");
    // R6: enable low, qualifier high
    step(1'b1, 1'b1, 1'b0, 16'hAAAA, "R6");
    // R8: double open replaces first half
    step(1'b0, 1'b1, 1'b1, 16'hBBBB, "R8");
    step(1'b1, 1'b1, 1'b1, 16'hCCCC, "R8");
    step(1'b1, 1'b1, 1'b1, 16'hDDDD, "R8");
    step(1'b0, 1'b1, 1'b1, 16'hEEEE, "R8");
    step(1'b1, 1'b1, 1'b1, 16'h0F0F, "R8");
    // R2: falling-edge framing
    open_fall = 1'b1;
    step(1'b0, 1'b1, 1'b1, 16'h1234, "R2");
    step(1'b1, 1'b1, 1'b1, 16'h5678, "R2");
    step(1'b0, 1'b1, 1'b1, 16'h9ABC, "R2");
    step(1'b1, 1'b0, 1'b1, 16'hDEF0, "R5");
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic lvl;
      if (($urandom % 40) == 0) open_fall = ~open_fall;
      lvl = (($urandom % 16) == 0) ? bus_lvl : ~bus_lvl;
      step(lvl, ($urandom % 4) != 0, ($urandom % 8) != 0, DW'($urandom), "");
    end
    // reset in the middle of a held pair
    rst = 1'b1;
    step(1'b0, 1'b1, 1'b1, 16'h0001, "R7");
    rst = 1'b0;
    step(1'b1, 1'b1, 1'b1, 16'h0002, "R7");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule